// File: doc/BRIEF.md
# Multiplexed LED Scan Driver

This block sequences a common-cathode multiplexed LED panel out of a 14-byte display memory. A frame visits each active grid in turn and then spends one slot with the panel dark so that key scanning can take place. Each slot lasts sixteen scan ticks. Within its slot a grid is lit only for a number of leading sub-slots that a 3-bit dimming code picks from a fixed, non-linear table. The host sets three things through single-cycle write strobes: a 2-bit split mode, a display-on flag and the dimming code.

The split mode trades grids for segments, from 4 grids with 13 segments up to 7 grids with 10 segments. Three shared pins each pair a high segment number with a high grid number. Such a pin acts as a grid when its grid is part of the active count, and as a segment otherwise.

Display data comes from an external memory with a combinational read port. The block fetches the two bytes for the next grid during the last two sub-slots of the current slot. It raises a one-clock frame-end strobe each time the key slot finishes.

Top module: `led_scan_driver`

## Requirements
- R1: After reset the mode is 2'b11 (7 grids, 10 segments), the display is off and the dimming code is 3'b000. All grid lines and shared pins are high, `seg` is zero and `frame_end` is low. Scanning starts at the beginning of the key slot.
- R2: `mode_val` picks the number of grids G = 4 + mode_val (00→4, 01→5, 10→6, 11→7). Shared pin `share[j]` (j = 0, 1, 2) pairs segment 12+j with grid 7−j. It acts as that grid when 7−j ≤ G and as that segment otherwise.
- R3: Grid n (1-based) takes byte 2(n−1) for segments 1–8 (bit i drives segment i+1) and byte 2(n−1)+1 for the rest. In that second byte, bits 1:0 drive segments 9–10 and bits 6:4 drive segments 12–14 (bit 4+j drives `share[j]` when it is a segment). Bits 7, 3 and 2 of that byte have no effect. `seg[i]` is segment i+1.
- R4: The number of lit leading sub-slots per grid slot is taken from the dimming code: 000→1, 001→2, 010→4, 011→10, 100→11, 101→12, 110→13, 111→14. Outside that window every grid and segment is inactive.
- R5: While the display is off, every grid and shared-grid pin is high and every segment is low, and frame-end strobes keep coming once per frame.
- R6: A mode write with a value different from the current mode turns the display off. It also restarts the scan at the start of the key slot, and this wins over a tick or control write in the same cycle. A write of the current mode changes nothing.
- R7: Each `tick` advances the sub-slot. A frame is G grid slots followed by one key slot, each 16 ticks long. `frame_end` is high for the single clock after the tick that ends the key slot.
- R8: An active grid is driven low and an active segment high. At most one grid is active at a time, and only during its own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Scan clock enable, one sub-slot per pulse |
| mode_wr | input | 1 | Strobe: load `mode_val` |
| mode_val | input | 2 | Grid/segment split code |
| ctrl_wr | input | 1 | Strobe: load `ctrl_on` and `ctrl_dim` |
| ctrl_on | input | 1 | Display on (1) / off (0) |
| ctrl_dim | input | 3 | Dimming code |
| mem_addr | output | 4 | Display memory read address |
| mem_data | input | 8 | Display memory read data, combinational from `mem_addr` |
| seg | output | 10 | Segments 1–10, active high |
| grid_n | output | 4 | Grids 1–4, active low |
| share | output | 3 | Shared segment-12+j / grid-7−j pins |
| frame_end | output | 1 | One-clock pulse after the key slot ends |

## Verification
All scan outputs are decoded directly from registers that change on the clock edge where `tick` or a write strobe is sampled. The new value of each scan output is therefore due in the clock cycle that follows that edge. `frame_end` is high for that one cycle only. The bench holds each strobe high across exactly one rising edge, from one falling edge to the next. It then samples at the second falling edge, against a sub-slot/slot model that it advances once per tick. Because memory writes in the bench happen only before a mode restart, the next-grid prefetch always sees the bytes that the model expects.

// File: rtl/scan_pkg.sv
// Shared constants and decode functions for the multiplexed LED scan driver.
// Assumes 16 sub-slots per slot and at most 7 grids (fixed by the split table).
package scan_pkg;
    localparam int SUB_SLOTS  = 16;
    localparam int SUB_W      = $clog2(SUB_SLOTS);
    localparam int MAX_GRIDS  = 7;
    localparam int SLOT_W     = $clog2(MAX_GRIDS + 1);
    localparam int MEM_AW     = SLOT_W + 1;
    localparam int FIXED_GRID = 4;
    localparam int LOW_SEGS   = 10;
    localparam int SHARED     = MAX_GRIDS - FIXED_GRID;
    localparam int LEN_W      = SUB_W + 1;
    localparam logic [1:0] RESET_MODE = 2'b11;

    // Number of active grids for a split code.
    function automatic logic [SLOT_W-1:0] grids_of(input logic [1:0] m);
        return SLOT_W'(FIXED_GRID) + SLOT_W'(m);
    endfunction

    // Lit sub-slots per grid slot for a dimming code.
    function automatic logic [LEN_W-1:0] on_len(input logic [2:0] d);
        case (d)
            3'd0:    return LEN_W'(1);
            3'd1:    return LEN_W'(2);
            3'd2:    return LEN_W'(4);
            3'd3:    return LEN_W'(10);
            3'd4:    return LEN_W'(11);
            3'd5:    return LEN_W'(12);
            3'd6:    return LEN_W'(13);
            default: return LEN_W'(14);
        endcase
    endfunction
endpackage

// File: rtl/scan_timer.sv
// Sub-slot and slot counters. Slot indices 0..G-1 are grids, index G is the
// key slot. A restart jumps to the start of the key slot of the new split.
// Assumes restart and tick are single-cycle qualified inputs.
module scan_timer
    import scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic [SLOT_W-1:0] restart_slot,
    input  logic [SLOT_W-1:0] ngrid,
    output logic [SLOT_W-1:0] slot_q,
    output logic [SUB_W-1:0]  sub_q,
    output logic              frame_end
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_SLOTS - 1);

    // Advance sub-slot per tick, step slot on wrap, flag the end of the key slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q    <= grids_of(RESET_MODE);
            sub_q     <= '0;
            frame_end <= 1'b0;
        end else begin
            frame_end <= 1'b0;
            if (restart) begin
                slot_q <= restart_slot;
                sub_q  <= '0;
            end else if (tick) begin
                sub_q <= sub_q + SUB_W'(1);
                if (sub_q == SUB_LAST) begin
                    if (slot_q == ngrid) begin
                        slot_q    <= '0;
                        frame_end <= 1'b1;
                    end else begin
                        slot_q <= slot_q + SLOT_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/scan_fetch.sv
// Prefetches the two display bytes of the next grid: the even byte is
// captured on the tick leaving sub-slot 14, the odd byte on the tick leaving
// sub-slot 15, when both move into the active pair.
// Assumes the memory read port is combinational.
module scan_fetch
    import scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SLOT_W-1:0] slot_q,
    input  logic [SUB_W-1:0]  sub_q,
    input  logic [SLOT_W-1:0] ngrid,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [7:0]        mem_data,
    output logic [7:0]        lo_q,
    output logic [7:0]        hi_q
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_SLOTS - 1);
    localparam logic [SUB_W-1:0] SUB_PREV = SUB_W'(SUB_SLOTS - 2);

    logic [SLOT_W-1:0] next_g;
    logic [7:0]        shadow_lo;

    // Grid shown in the following slot (grid 0 stands in when the key slot follows).
    always_comb begin
        if (slot_q == ngrid || (slot_q + SLOT_W'(1)) == ngrid)
            next_g = '0;
        else
            next_g = slot_q + SLOT_W'(1);
    end

    assign mem_addr = {next_g, sub_q == SUB_LAST};

    // Capture the prefetched bytes at the two final ticks of a slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_lo <= '0;
            lo_q      <= '0;
            hi_q      <= '0;
        end else if (tick) begin
            if (sub_q == SUB_PREV) begin
                shadow_lo <= mem_data;
            end else if (sub_q == SUB_LAST) begin
                lo_q <= shadow_lo;
                hi_q <= mem_data;
            end
        end
    end
endmodule

// File: rtl/scan_drive.sv
// Decodes pin levels from the scan position and the active byte pair.
// Grids are active low, segments active high; shared pins take the role
// the split gives them. Purely combinational.
module scan_drive
    import scan_pkg::*;
(
    input  logic [SLOT_W-1:0]   slot_q,
    input  logic [SUB_W-1:0]    sub_q,
    input  logic [SLOT_W-1:0]   ngrid,
    input  logic                on_q,
    input  logic [2:0]          dim_q,
    input  logic [7:0]          lo_q,
    input  logic [7:0]          hi_q,
    output logic [LOW_SEGS-1:0] seg,
    output logic [FIXED_GRID-1:0] grid_n,
    output logic [SHARED-1:0]   share
);
    logic lit;

    // Lit only with display on, in a grid slot, inside the dimming window.
    assign lit = on_q && (slot_q < ngrid) && ({1'b0, sub_q} < on_len(dim_q));

    assign seg = lit ? {hi_q[1:0], lo_q} : '0;

    for (genvar k = 0; k < FIXED_GRID; k++) begin : g_grid
        assign grid_n[k] = !(lit && slot_q == SLOT_W'(k));
    end

    for (genvar j = 0; j < SHARED; j++) begin : g_share
        localparam logic [SLOT_W-1:0] GIDX = SLOT_W'(MAX_GRIDS - 1 - j);
        // Grid role when its grid index is in range, else segment 12+j.
        always_comb begin
            if (GIDX < ngrid)
                share[j] = !(lit && slot_q == GIDX);
            else
                share[j] = lit && hi_q[4+j];
        end
    end
endmodule

// File: rtl/led_scan_driver.sv
// Top of the multiplexed LED scan driver: holds the split mode, display-on
// flag and dimming code, and joins timer, prefetch and pin decode.
// Assumes single-cycle write strobes and a combinational memory read port.
module led_scan_driver
    import scan_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  mode_wr,
    input  logic [1:0]            mode_val,
    input  logic                  ctrl_wr,
    input  logic                  ctrl_on,
    input  logic [2:0]            ctrl_dim,
    output logic [MEM_AW-1:0]     mem_addr,
    input  logic [7:0]            mem_data,
    output logic [LOW_SEGS-1:0]   seg,
    output logic [FIXED_GRID-1:0] grid_n,
    output logic [SHARED-1:0]     share,
    output logic                  frame_end
);
    logic [1:0]        mode_q;
    logic              on_q;
    logic [2:0]        dim_q;
    logic              mode_change;
    logic [SLOT_W-1:0] ngrid;
    logic [SLOT_W-1:0] slot_q;
    logic [SUB_W-1:0]  sub_q;
    logic [7:0]        lo_q;
    logic [7:0]        hi_q;

    assign mode_change = mode_wr && (mode_val != mode_q);
    assign ngrid       = grids_of(mode_q);

    // Configuration registers; a real mode change forces the display off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RESET_MODE;
            on_q   <= 1'b0;
            dim_q  <= 3'd0;
        end else begin
            if (ctrl_wr) begin
                on_q  <= ctrl_on;
                dim_q <= ctrl_dim;
            end
            if (mode_change) begin
                mode_q <= mode_val;
                on_q   <= 1'b0;
            end
        end
    end

    scan_timer u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .restart      (mode_change),
        .restart_slot (grids_of(mode_val)),
        .ngrid        (ngrid),
        .slot_q       (slot_q),
        .sub_q        (sub_q),
        .frame_end    (frame_end)
    );

    scan_fetch u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick && !mode_change),
        .slot_q   (slot_q),
        .sub_q    (sub_q),
        .ngrid    (ngrid),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .lo_q     (lo_q),
        .hi_q     (hi_q)
    );

    scan_drive u_drive (
        .slot_q (slot_q),
        .sub_q  (sub_q),
        .ngrid  (ngrid),
        .on_q   (on_q),
        .dim_q  (dim_q),
        .lo_q   (lo_q),
        .hi_q   (hi_q),
        .seg    (seg),
        .grid_n (grid_n),
        .share  (share)
    );
endmodule

// File: rtl/scan_checker.sv
// Temporal checks for the scan driver, bound to every instance of the top.
module scan_checker
    import scan_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  mode_wr,
    input logic [1:0]            mode_val,
    input logic                  ctrl_wr,
    input logic [1:0]            mode_q,
    input logic                  on_q,
    input logic [2:0]            dim_q,
    input logic [SLOT_W-1:0]     slot_q,
    input logic [SUB_W-1:0]      sub_q,
    input logic [LOW_SEGS-1:0]   seg,
    input logic [FIXED_GRID-1:0] grid_n,
    input logic                  frame_end
);
    p_one_grid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~grid_n) <= 1);

    p_dark_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !on_q |-> (seg == '0 && grid_n == '1));

    p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, sub_q} >= on_len(dim_q)) |-> (seg == '0 && grid_n == '1));

    p_mode_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_val != mode_q) |=> !on_q);

    p_same_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_val == mode_q && !ctrl_wr) |=> (on_q == $past(on_q)));

    p_sub_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(mode_wr && mode_val != mode_q)) |=> (sub_q == $past(sub_q) + SUB_W'(1)));

    p_frame_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (slot_q == '0 && sub_q == '0));
endmodule

bind led_scan_driver scan_checker u_scan_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode_wr   (mode_wr),
    .mode_val  (mode_val),
    .ctrl_wr   (ctrl_wr),
    .mode_q    (mode_q),
    .on_q      (on_q),
    .dim_q     (dim_q),
    .slot_q    (slot_q),
    .sub_q     (sub_q),
    .seg       (seg),
    .grid_n    (grid_n),
    .frame_end (frame_end)
);

// File: tb/tb_led_scan_driver.sv
module tb_led_scan_driver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_val = 2'b00;
    logic       ctrl_wr = 1'b0;
    logic       ctrl_on = 1'b0;
    logic [2:0] ctrl_dim = 3'd0;
    logic [3:0] mem_addr;
    logic [7:0] mem_data;
    logic [9:0] seg;
    logic [3:0] grid_n;
    logic [2:0] share;
    logic       frame_end;

    logic [7:0] mem [14];
    assign mem_data = (mem_addr < 4'd14) ? mem[mem_addr] : 8'h00;

    always #10 clk = ~clk;

    led_scan_driver dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .mode_wr(mode_wr), .mode_val(mode_val),
        .ctrl_wr(ctrl_wr), .ctrl_on(ctrl_on), .ctrl_dim(ctrl_dim),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .seg(seg), .grid_n(grid_n), .share(share), .frame_end(frame_end)
    );

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 0;

    // Reference model of the scan position and configuration.
    int m_slot = 7, m_sub = 0, m_mode = 3, m_on = 0, m_dim = 0;
    bit m_fe = 0;

    function automatic int ng();
        return 4 + m_mode;
    endfunction

    function automatic int len_of(int d);
        case (d)
            0: return 1;  1: return 2;  2: return 4;  3: return 10;
            4: return 11; 5: return 12; 6: return 13; default: return 14;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare all scan outputs with the model.
    task automatic check_state(string tag);
        bit lit;
        logic [7:0] lo, hi;
        logic [9:0] e_seg;
        logic [3:0] e_grid;
        logic [2:0] e_share;
        lit = (m_on != 0) && (m_slot < ng()) && (m_sub < len_of(m_dim));
        lo = (m_slot < ng()) ? mem[2*m_slot] : 8'h00;
        hi = (m_slot < ng()) ? mem[2*m_slot+1] : 8'h00;
        e_seg = lit ? {hi[1:0], lo} : 10'h0;
        for (int k = 0; k < 4; k++) e_grid[k] = !(lit && m_slot == k);
        for (int j = 0; j < 3; j++) begin
            if (6 - j < ng()) e_share[j] = !(lit && m_slot == 6 - j);
            else              e_share[j] = lit && hi[4+j];
        end
        chk(tag, {14'h0, frame_end, share, grid_n, seg},
                 {14'h0, m_fe, e_share, e_grid, e_seg});
    endtask

    task automatic do_tick(string tag);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        m_sub++;
        m_fe = 0;
        if (m_sub == 16) begin
            m_sub = 0;
            if (m_slot == ng()) begin m_slot = 0; m_fe = 1; end
            else m_slot++;
        end
        check_state(tag);
    endtask

    task automatic write_mode(int v);
        @(negedge clk) begin mode_wr = 1'b1; mode_val = 2'(v); end
        @(negedge clk) mode_wr = 1'b0;
        if (v != m_mode) begin
            m_mode = v; m_on = 0; m_slot = ng(); m_sub = 0;
        end
        m_fe = 0;
        check_state("R6 mode write");
    endtask

    task automatic write_ctrl(int on, int dim);
        @(negedge clk) begin ctrl_wr = 1'b1; ctrl_on = 1'(on); ctrl_dim = 3'(dim); end
        @(negedge clk) ctrl_wr = 1'b0;
        m_on = on; m_dim = dim; m_fe = 0;
        check_state("R4 ctrl write");
    endtask

    task automatic run_to_frame_end(string tag);
        for (int i = 0; i < 300; i++) begin
            do_tick(tag);
            if (m_fe) break;
        end
    endtask

    // R1: reset state.
    task automatic t_reset();
        chk("R1 reset pins", {19'h0, frame_end, share, grid_n, seg}, {19'h0, 1'b0, 3'b111, 4'hF, 10'h0});
    endtask

    // R5/R7: display off, frames still counted.
    task automatic t_off_frames();
        int fe = 0;
        for (int i = 0; i < 16 + 128; i++) begin
            do_tick("R5 off scan");
            if (frame_end) fe++;
        end
        chk("R7 frame count off", 32'(fe), 32'd2);
        chk("R5 frame end on last tick", {31'h0, frame_end}, 32'd1);
    endtask

    // R2/R3/R8: every split with full brightness, checked each tick.
    task automatic t_patterns();
        for (int m = 0; m < 4; m++) begin
            int ticks;
            write_mode(m);
            write_ctrl(1, 7);
            ticks = 16 + 2 * (m + 5) * 16;
            for (int i = 0; i < ticks; i++) do_tick("R2 R3 R8 pattern");
        end
    endtask

    // R4: lit sub-slots per slot for each dimming code.
    task automatic t_dim();
        write_mode(0);
        write_mode(3);
        for (int d = 0; d < 8; d++) begin
            int lit_cnt = 0;
            write_ctrl(1, d);
            run_to_frame_end("R4 align");
            for (int i = 0; i < 128; i++) begin
                do_tick("R4 dim scan");
                if (grid_n[0] == 1'b0) lit_cnt++;
            end
            chk($sformatf("R4 dim code %0d", d), 32'(lit_cnt), 32'(len_of(d)));
        end
    endtask

    // R6: same-mode write ignored, different mode blanks and restarts.
    task automatic t_mode_write();
        int fe = 0;
        write_ctrl(1, 7);
        run_to_frame_end("R6 align");
        write_mode(3);
        chk("R6 same mode keeps grid 1 lit", {28'h0, grid_n}, {28'h0, 4'b1110});
        for (int i = 0; i < 128; i++) begin
            do_tick("R6 same mode scan");
            if (frame_end) fe++;
        end
        chk("R6 same mode frame timing", {31'h0, frame_end}, 32'd1);
        chk("R6 same mode one frame end", 32'(fe), 32'd1);
        write_mode(2);
        chk("R6 new mode blanks", {25'h0, share, grid_n}, {25'h0, 3'b110, 4'hF});
        for (int i = 0; i < 16; i++) do_tick("R6 restart scan");
        chk("R6 restart at key slot", {31'h0, frame_end}, 32'd1);
        chk("R6 display stays off", {28'h0, grid_n}, {28'h0, 4'hF});
    endtask

    // R3: unused bits of the odd byte drive nothing.
    task automatic t_ignored_bits();
        mem[0] = 8'h00;
        mem[1] = 8'h8C;
        write_mode(0);
        write_ctrl(1, 7);
        for (int i = 0; i < 16; i++) do_tick("R3 ignored scan");
        chk("R3 ignored bits seg", {22'h0, seg}, 32'h0);
        chk("R3 ignored bits shared segs", {29'h0, share}, 32'h0);
        chk("R3 grid 1 active", {28'h0, grid_n}, {28'h0, 4'b1110});
    endtask

    initial begin
        for (int i = 0; i < 14; i++) mem[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        check_state("R1 after reset");
        t_off_frames();
        t_patterns();
        t_dim();
        t_mode_write();
        t_ignored_bits();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end
endmodule